// File: doc/BRIEF.md
# Three-Channel Match Timer with Snapshot Readout

This block holds three up-counters that advance on a slow functional clock, `fclk`. The configuration registers and the read port sit on a faster, unrelated bus clock, `clk`. Each channel has the following:

- three comparators;
- a preload value;
- a reload-select mask, which names the comparators that send the counter back to its preload value.

A shared run register starts and stops the channels. When a channel is stopped, its counter is parked at the preload value.

Software never reads a live counter. To read one, it writes 1 to the channel's capture register. The request is carried into the counter domain, where a snapshot is taken. The snapshot is then handed back to the bus domain, and a later read of the same capture register returns it.

Comparator hits while running are also carried into the bus domain. There they set sticky status bits, which are masked per bit into one interrupt line per channel.

Top module: `match_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq` is 0.
- R2: Word addresses:
  - 0-8: compare value for channel c, comparator k, at address 3c+k.
  - 9-11: preload for channel 0, 1, 2.
  - 12-14: reload-select mask, 3 bits, bit k selects comparator k.
  - 15: run, bit c enables channel c.
  - 16-18: status, read only.
  - 19-21: interrupt enable.
  - 22-24: clear.
  - 25-27: capture.
  - Writable registers read back what was written, within their widths.
- R3: While a channel's run bit is 0, its counter holds the preload value, and a capture returns that value, following preload changes.
- R4: A write to a capture register starts a snapshot only if data bit 0 is 1. A read of the capture register returns the last completed snapshot.
- R5: While running, a counter increases by exactly one per `fclk` tick, apart from reloads.
- R6: A counter reloads its preload value on the tick after it equals a comparator whose select bit is set. A comparator whose select bit is clear never reloads it.
- R7: Status bit k of a channel is set when the running counter equals comparator k, and it stays set until cleared.
- R8: `irq[c]` is 1 exactly when some status bit of channel c has its interrupt-enable bit set.
- R9: Writing 1 to bit k of a clear register clears status bit k only. Bits written 0 are unaffected.
- R10: With no reload selected, a counter passes 0xFFFFFFFF and wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| fclk | input | 1 | Counter clock, slower than and unrelated to `clk` |
| addr | input | 6 | Word address |
| wr_en | input | 1 | Write strobe, sampled on `clk` |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 3 | Per-channel masked match interrupt |

## Verification
The hardest situation to reach from the ports is proving what a counter did while it was running. Its value is visible only through a snapshot taken a few ticks after the request, at a time that depends on how the two clocks line up.

The bench therefore counts `fclk` edges itself and accepts a snapshot inside a small window around the predicted count. It relies on exact values only when a channel is parked.

For the reload and wrap cases, it chooses preload and compare values a few ticks away from each other. This lets the whole cycle be crossed within a short run. It also sets a comparator to the value just past where a wrong reload would land, so a wrong reload shows up in both the status bits and the snapshot.

// File: rtl/match_timer.sv
module match_timer #(
  parameter int NCH  = 3,
  parameter int NCMP = 3,
  parameter int CW   = 32,
  parameter int AW   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fclk,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic [NCH-1:0] irq
);
  localparam int NM      = NCH * NCMP;
  localparam int A_MATCH = 0;
  localparam int A_PRE   = A_MATCH + NM;
  localparam int A_SEL   = A_PRE + NCH;
  localparam int A_RUN   = A_SEL + NCH;
  localparam int A_STS   = A_RUN + 1;
  localparam int A_IE    = A_STS + NCH;
  localparam int A_CLR   = A_IE + NCH;
  localparam int A_CAP   = A_CLR + NCH;

  logic [CW-1:0]   match_q [NM];
  logic [CW-1:0]   pre_q   [NCH];
  logic [NCMP-1:0] sel_q   [NCH];
  logic [NCMP-1:0] ie_q    [NCH];
  logic [NCMP-1:0] sts_q   [NCH];
  logic [CW-1:0]   cap_q   [NCH];
  logic [NCH-1:0]  run_q, req_t, ack_s1, ack_s2, ack_s3;
  logic [NM-1:0]   hit_s1, hit_s2, hit_s3;

  logic [CW-1:0]   snap_w  [NCH];
  logic [NCH-1:0]  ack_t;
  logic [NM-1:0]   hit_t;
  logic [NM-1:0]   sts_flat;
  logic [NCH*CW-1:0] cnt_flat, pre_flat;

  logic [1:0]      frst_q;
  logic            frst_n;
  logic [NCH-1:0]  run_f1, run_f2, req_f1, req_f2, req_f3;

  wire [NCH-1:0] busy = req_t ^ ack_s2;
  wire [NCH-1:0] done = ack_s2 ^ ack_s3;
  wire [NM-1:0]  ev   = hit_s2 ^ hit_s3;

  // bus clock domain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NM; i++) match_q[i] <= '0;
      for (int c = 0; c < NCH; c++) begin
        pre_q[c] <= '0; sel_q[c] <= '0; ie_q[c] <= '0;
        sts_q[c] <= '0; cap_q[c] <= '0;
      end
      run_q <= '0; req_t <= '0;
      ack_s1 <= '0; ack_s2 <= '0; ack_s3 <= '0;
      hit_s1 <= '0; hit_s2 <= '0; hit_s3 <= '0;
    end else begin
      ack_s1 <= ack_t;  ack_s2 <= ack_s1; ack_s3 <= ack_s2;
      hit_s1 <= hit_t;  hit_s2 <= hit_s1; hit_s3 <= hit_s2;
      for (int i = 0; i < NM; i++)
        if (wr_en && addr == AW'(A_MATCH + i)) match_q[i] <= wdata;
      if (wr_en && addr == AW'(A_RUN)) run_q <= wdata[NCH-1:0];
      for (int c = 0; c < NCH; c++) begin
        if (wr_en && addr == AW'(A_PRE + c)) pre_q[c] <= wdata;
        if (wr_en && addr == AW'(A_SEL + c)) sel_q[c] <= wdata[NCMP-1:0];
        if (wr_en && addr == AW'(A_IE + c))  ie_q[c]  <= wdata[NCMP-1:0];
        if (wr_en && addr == AW'(A_CAP + c) && wdata[0] && !busy[c])
          req_t[c] <= ~req_t[c];
        if (done[c]) cap_q[c] <= snap_w[c];
        sts_q[c] <= (sts_q[c] & ~((wr_en && addr == AW'(A_CLR + c)) ? wdata[NCMP-1:0] : '0))
                  | ev[c*NCMP +: NCMP];
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NM; i++)
      if (addr == AW'(A_MATCH + i)) rdata = match_q[i];
    for (int c = 0; c < NCH; c++) begin
      if (addr == AW'(A_PRE + c)) rdata = pre_q[c];
      if (addr == AW'(A_SEL + c)) rdata = CW'(sel_q[c]);
      if (addr == AW'(A_STS + c)) rdata = CW'(sts_q[c]);
      if (addr == AW'(A_IE + c))  rdata = CW'(ie_q[c]);
      if (addr == AW'(A_CAP + c)) rdata = cap_q[c];
    end
    if (addr == AW'(A_RUN)) rdata = CW'(run_q);
  end

  // counter clock domain
  always_ff @(posedge fclk or negedge rst_n)
    if (!rst_n) frst_q <= '0;
    else        frst_q <= {frst_q[0], 1'b1};
  assign frst_n = frst_q[1];

  always_ff @(posedge fclk or negedge frst_n)
    if (!frst_n) begin
      run_f1 <= '0; run_f2 <= '0;
      req_f1 <= '0; req_f2 <= '0; req_f3 <= '0;
    end else begin
      run_f1 <= run_q; run_f2 <= run_f1;
      req_f1 <= req_t; req_f2 <= req_f1; req_f3 <= req_f2;
    end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CW-1:0]   cnt, snap;
    logic [NCMP-1:0] eq, tog;
    logic            ack;
    for (genvar k = 0; k < NCMP; k++) begin : g_cmp
      assign eq[k] = (cnt == match_q[c*NCMP + k]);
    end
    always_ff @(posedge fclk or negedge frst_n)
      if (!frst_n) begin
        cnt <= '0; snap <= '0; tog <= '0; ack <= 1'b0;
      end else begin
        if (!run_f2[c])              cnt <= pre_q[c];
        else if (|(eq & sel_q[c]))   cnt <= pre_q[c];
        else                         cnt <= cnt + 1'b1;
        if (run_f2[c]) tog <= tog ^ eq;
        if (req_f2[c] ^ req_f3[c]) begin
          snap <= cnt;
          ack  <= ~ack;
        end
      end
    assign snap_w[c]                = snap;
    assign ack_t[c]                 = ack;
    assign hit_t[c*NCMP +: NCMP]    = tog;
    assign irq[c]                   = |(sts_q[c] & ie_q[c]);
    assign sts_flat[c*NCMP +: NCMP] = sts_q[c];
    assign cnt_flat[c*CW +: CW]     = cnt;
    assign pre_flat[c*CW +: CW]     = pre_q[c];
  end
endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk #(
  parameter int NCH  = 3,
  parameter int NCMP = 3,
  parameter int CW   = 32,
  parameter int AW   = 6,
  parameter int A_CLR = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fclk,
  input logic              frst_n,
  input logic [AW-1:0]     addr,
  input logic              wr_en,
  input logic [NCMP-1:0]   clr_bits,
  input logic [NCH-1:0]    run_f2,
  input logic [NCH-1:0]    req_t,
  input logic [NCH-1:0]    ack_s2,
  input logic [NCH*NCMP-1:0] sts_flat,
  input logic [NCH*CW-1:0] cnt_flat,
  input logic [NCH*CW-1:0] pre_flat
);
  for (genvar c = 0; c < NCH; c++) begin : g_c
    p_hold_preload_r3: assert property (@(posedge fclk) disable iff (!frst_n)
      !run_f2[c] |=> cnt_flat[c*CW +: CW] == $past(pre_flat[c*CW +: CW]));

    p_count_step_r5: assert property (@(posedge fclk) disable iff (!frst_n)
      run_f2[c] |=> (cnt_flat[c*CW +: CW] == $past(cnt_flat[c*CW +: CW]) + 1'b1)
                 || (cnt_flat[c*CW +: CW] == $past(pre_flat[c*CW +: CW])));

    p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_t[c] != ack_s2[c]) |=> $stable(req_t[c]));

    for (genvar k = 0; k < NCMP; k++) begin : g_k
      p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sts_flat[c*NCMP + k] && !(wr_en && addr == AW'(A_CLR + c) && clr_bits[k])
        |=> sts_flat[c*NCMP + k]);
    end
  end
endmodule

bind match_timer match_timer_chk #(
  .NCH(NCH), .NCMP(NCMP), .CW(CW), .AW(AW), .A_CLR(A_CLR)
) i_chk (
  .clk(clk), .rst_n(rst_n), .fclk(fclk), .frst_n(frst_n),
  .addr(addr), .wr_en(wr_en), .clr_bits(wdata[NCMP-1:0]),
  .run_f2(run_f2), .req_t(req_t), .ack_s2(ack_s2),
  .sts_flat(sts_flat), .cnt_flat(cnt_flat), .pre_flat(pre_flat)
);

// File: tb/test_match_timer.sv
`timescale 1ns/1ps
module test_match_timer;
  localparam int A_PRE = 9, A_SEL = 12, A_RUN = 15, A_STS = 16;
  localparam int A_IE = 19, A_CLR = 22, A_CAP = 25;

  logic        clk = 0, fclk = 0, rst_n = 0;
  logic [5:0]  addr = '0;
  logic        wr_en = 0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  irq;

  int nchk = 0, nfail = 0;
  int fedges = 0;
  bit finished = 0;
  logic [2:0] ie_sh [3];

  always #5    clk  = ~clk;
  always #18.5 fclk = ~fclk;
  always @(posedge fclk) fedges++;

  match_timer i_match_timer (.clk(clk), .rst_n(rst_n), .fclk(fclk), .addr(addr),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq(irq));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    addr = 6'(a); wdata = d; wr_en = 1;
    @(posedge clk);
    if (a >= A_IE && a < A_IE + 3) ie_sh[a - A_IE] = d[2:0];
    #1 wr_en = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk);
    addr = 6'(a); wr_en = 0;
    #1 v = rdata;
  endtask

  task automatic cap(input int ch, output logic [31:0] v);
    wr(A_CAP + ch, 32'd1);
    repeat (30) @(posedge clk);
    rd(A_CAP + ch, v);
  endtask

  // per-clock model comparison: a channel with no enabled bits never interrupts (R8)
  always @(posedge clk) begin
    #2;
    if (rst_n && !finished)
      for (int c = 0; c < 3; c++)
        check(!(irq[c] && ie_sh[c] == 3'b000), "R8 irq without enable", irq[c], 0);
  end

  initial begin
    #(10 * 150000);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected done");
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    int e0, n;
    for (int c = 0; c < 3; c++) ie_sh[c] = 3'b000;
    repeat (5) @(posedge clk);
    rst_n = 1;
    repeat (10) @(posedge clk);

    // R1 reset state
    for (int a = 0; a < 28; a++) begin
      rd(a, v);
      check(v == 0, "R1 reset register", v, 0);
    end
    check(irq == 0, "R1 reset irq", irq, 0);

    // R2 readback
    wr(4, 32'hA5A5_0001);       rd(4, v);        check(v == 32'hA5A5_0001, "R2 compare", v, 32'hA5A5_0001);
    wr(A_PRE + 1, 32'h1234);    rd(A_PRE + 1, v); check(v == 32'h1234, "R2 preload", v, 32'h1234);
    wr(A_SEL + 1, 32'hFFFF_FFFA); rd(A_SEL + 1, v); check(v == 32'h2, "R2 select width", v, 2);
    wr(A_IE + 1, 32'h5);        rd(A_IE + 1, v);  check(v == 32'h5, "R2 enable", v, 5);
    wr(A_IE + 1, 32'h0);

    // R3 parked channel returns preload
    wr(A_SEL + 1, 0);
    wr(A_PRE + 1, 77);  repeat (5) @(posedge clk);
    cap(1, v); check(v == 77, "R3 parked capture", v, 77);
    wr(A_PRE + 1, 200); repeat (5) @(posedge clk);
    cap(1, v); check(v == 200, "R3 preload follows", v, 200);

    // R4 capture write with bit 0 clear does nothing
    wr(A_PRE + 1, 300); repeat (5) @(posedge clk);
    wr(A_CAP + 1, 32'hFFFF_FFFE);
    repeat (30) @(posedge clk);
    rd(A_CAP + 1, v); check(v == 200, "R4 ignored request", v, 200);

    // R5 running count
    for (int k = 0; k < 3; k++) wr(3 + k, 32'hFFFF_0000);
    wr(A_PRE + 1, 1000);
    wr(A_RUN, 3'b010); e0 = fedges;
    repeat (100) @(posedge clk);
    n = fedges - e0;
    cap(1, v);
    check(v + 4 >= 1000 + n && v <= 1000 + n + 4, "R5 count window", v, 1000 + n);
    repeat (60) @(posedge clk);
    n = fedges - e0;
    cap(1, v2);
    check(v2 > v && v2 + 4 >= 1000 + n && v2 <= 1000 + n + 4, "R5 count advance", v2, 1000 + n);

    // R3 stopped channel returns to preload
    wr(A_RUN, 0); repeat (10) @(posedge clk);
    cap(1, v); check(v == 1000, "R3 stop parks", v, 1000);

    // R6 R7 R8 reload on selected comparator
    wr(A_PRE + 2, 5); wr(6, 9); wr(7, 32'hFFFF_FFF0); wr(8, 32'hFFFF_FFF0);
    wr(A_SEL + 2, 3'b001); wr(A_IE + 2, 3'b001);
    wr(A_RUN, 3'b100);
    repeat (40) @(posedge clk);
    for (int i = 0; i < 4; i++) begin
      cap(2, v); check(v >= 5 && v <= 9, "R6 reload range", v, 7);
    end
    rd(A_STS + 2, v); check(v == 3'b001, "R7 status set", v, 1);
    check(irq[2] == 1'b1, "R8 irq asserted", irq[2], 1);

    // R9 clear
    wr(A_RUN, 0); repeat (20) @(posedge clk);
    wr(A_CLR + 2, 3'b001);
    rd(A_STS + 2, v); check(v == 0, "R9 status cleared", v, 0);
    check(irq[2] == 1'b0, "R9 irq dropped", irq[2], 0);

    // R6 R8 R9 unselected comparator does not reload
    wr(A_PRE + 0, 0); wr(0, 1000); wr(1, 3); wr(2, 32'hFFFF_FFF0);
    wr(A_SEL + 0, 3'b001);
    wr(A_RUN, 3'b001);
    repeat (200) @(posedge clk);
    cap(0, v); check(v > 3 && v < 1000, "R6 no reload on unselected", v, 50);
    rd(A_STS + 0, v); check(v == 3'b010, "R7 only hit bit", v, 2);
    check(irq[0] == 1'b0, "R8 masked", irq[0], 0);
    wr(A_CLR + 0, 3'b101);
    rd(A_STS + 0, v); check(v == 3'b010, "R9 other bits kept", v, 2);
    wr(A_CLR + 0, 3'b010);
    rd(A_STS + 0, v); check(v == 0, "R9 bit cleared", v, 0);

    // R10 natural wrap
    wr(A_RUN, 0);
    wr(A_PRE + 0, 32'hFFFF_FFF0); wr(0, 32'hFFFF_FFF8); wr(A_SEL + 0, 0);
    repeat (20) @(posedge clk);
    wr(A_CLR + 0, 3'b111);
    rd(A_STS + 0, v); check(v == 0, "R9 clear before wrap", v, 0);
    wr(A_RUN, 3'b001);
    repeat (150) @(posedge clk);
    cap(0, v); check(v >= 1 && v <= 32'h3F, "R10 wrapped to zero", v, 32'h18);
    rd(A_STS + 0, v); check(v == 3'b111, "R7 hits across wrap", v, 7);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule